// File: doc/BRIEF.md
# Supply Supervisor Reset and Watchdog Controller

This block turns digitised supply-monitor flags and a processor heartbeat into the reset, power-fail and backup-select signals of a supervised system. The comparators, thresholds and power switches are external. The block sees only a flag for the supply being under the reset threshold, a flag for the supply being under the battery level, a flag from a power-fail comparator, and the heartbeat input with a flag that marks it as floating.

Reset is held for the whole time the supply is low, and for a fixed stretch after the supply recovers. A heartbeat that stops toggling for longer than the timeout causes a reset pulse of the same stretch. The heartbeat timer restarts after the pulse, so a stuck heartbeat produces a reset every timeout plus stretch. When the supply falls below both the threshold and the battery, the block selects the backup source. In that mode it forces the power-fail output low, keeps reset asserted and stops the watchdog. All times are parameters counted in clock ticks. The defaults are 1.6 s and 200 ms at 50 MHz.

Top module: `supv_ctrl`

## Requirements
- R1: After the synchronous reset `rst` is released with the supply good, `rst_o` stays 1 for exactly RESET_TICKS clock edges and then falls to 0.
- R2: `rst_n_o` is always the exact inverse of `rst_o`.
- R3: Each rising or falling transition of `wdog_i` restarts the watchdog. The input passes two synchroniser stages and an edge detector. If the last transition is driven in cycle L, reset rises in cycle L+3+TIMEOUT_TICKS.
- R4: If `wdog_i` is held constant, `rst_o` stays 0 for TIMEOUT_TICKS cycles and then 1 for RESET_TICKS cycles, repeating with a period of TIMEOUT_TICKS+RESET_TICKS. Transitions during reset are ignored.
- R5: `rst_o` is 1 on every cycle after a clock edge that samples `sup_low_i`=1. Once `sup_low_i` is sampled 0, `rst_o` stays 1 for RESET_TICKS more cycles.
- R6: `bat_sel_o`=1 means backup source. It sets only on an edge that samples both `sup_low_i` and `sup_below_bat_i` high. It holds while `sup_low_i` stays high, whatever the battery flag does, and it clears on the first edge that samples `sup_low_i`=0.
- R7: While `bat_sel_o`=1, `pfail_n_o`=0, `rst_o`=1 and `wdog_en_o`=0.
- R8: Outside backup mode, `pfail_n_o` is the inverse of `pf_cmp_low_i` with a latency of one clock.
- R9: While `wdog_float_i`=1, `wdog_en_o` is 0 (one clock of latency) and no watchdog reset occurs. When the flag is released, a full timeout starts one cycle after `wdog_en_o` returns to 1.
- R10: A `wdog_i` pulse of a single clock counts as two transitions. Reset then rises in cycle P+4+TIMEOUT_TICKS, where P is the cycle in which the pulse started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sup_low_i | input | 1 | Supply below the reset threshold |
| sup_below_bat_i | input | 1 | Supply below the battery voltage |
| wdog_i | input | 1 | Watchdog heartbeat from the processor |
| wdog_float_i | input | 1 | Heartbeat input is floating |
| pf_cmp_low_i | input | 1 | Power-fail comparator input is below its reference |
| rst_n_o | output | 1 | Active-low processor reset |
| rst_o | output | 1 | Active-high processor reset |
| pfail_n_o | output | 1 | Power-fail output, low on a failure |
| bat_sel_o | output | 1 | 1 selects the backup source |
| wdog_en_o | output | 1 | Watchdog is running |

## Verification
The assertions assume that the supply flags follow the physical ordering. The battery flag matters only while the supply-low flag is high, and backup mode never starts without the supply being low. The stimulus sets the supply flags only in that order and raises the battery flag alone once, to show that it has no effect. The assertions also assume that every input is stable around the clock edge. The stimulus changes inputs shortly after a rising edge and reads outputs on the falling edge. Heartbeat transitions are spaced well inside the timeout, except where a timeout is the aim.

// File: rtl/supv_pkg.sv
package supv_pkg;
  // reset sequencer states
  typedef enum logic {
    SEQ_RUN     = 1'b0,
    SEQ_STRETCH = 1'b1
  } seq_state_t;

  // width of a tick counter that must reach N-1
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/supv_edge_sync.sv
module supv_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic edge_o
);
  // chain[0..STAGES-1] synchronise, chain[STAGES] keeps the previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], din};
  end

  assign edge_o = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/supv_wdog_timer.sv
module supv_wdog_timer
  import supv_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 80_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic hold,
  input  logic kick,
  output logic expire
);
  localparam int CW = cnt_width(TIMEOUT_TICKS);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

  logic [CW-1:0] count;

  assign expire = enable && !hold && !kick && (count == LAST);

  always_ff @(posedge clk) begin
    if (rst || !enable || hold || kick || expire) count <= '0;
    else                                          count <= count + 1'b1;
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= LAST);

  // R3
  kick_restart_chk: assert property (@(posedge clk) disable iff (rst)
    kick |=> (count == '0));
endmodule

// File: rtl/supv_reset_seq.sv
module supv_reset_seq
  import supv_pkg::*;
#(
  parameter int RESET_TICKS = 10_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_low,
  input  logic wd_expire,
  output logic rst_active
);
  localparam int CW = cnt_width(RESET_TICKS);
  localparam logic [CW-1:0] LAST = CW'(RESET_TICKS - 1);

  seq_state_t    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || supply_low || wd_expire) begin
      state <= SEQ_STRETCH;
      cnt   <= '0;
    end else if (state == SEQ_STRETCH) begin
      if (cnt == LAST) begin
        state <= SEQ_RUN;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign rst_active = (state == SEQ_STRETCH);

  // R5
  sup_low_hold_chk: assert property (@(posedge clk) disable iff (rst)
    supply_low |=> rst_active);

  // R5
  stretch_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_active) |-> !$past(supply_low));

  // R4
  wd_fire_chk: assert property (@(posedge clk) disable iff (rst)
    wd_expire |=> rst_active);
endmodule

// File: rtl/supv_ctrl.sv
module supv_ctrl #(
  parameter int TIMEOUT_TICKS = 80_000_000,
  parameter int RESET_TICKS   = 10_000_000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sup_low_i,
  input  logic sup_below_bat_i,
  input  logic wdog_i,
  input  logic wdog_float_i,
  input  logic pf_cmp_low_i,
  output logic rst_n_o,
  output logic rst_o,
  output logic pfail_n_o,
  output logic bat_sel_o,
  output logic wdog_en_o
);
  logic bat_sel_q, bat_sel_d;
  logic en_q, pf_q;
  logic kick, expire, rst_active;

  // backup select: enter on both flags, leave as soon as supply recovers
  assign bat_sel_d = sup_low_i && (bat_sel_q || sup_below_bat_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      bat_sel_q <= 1'b0;
      en_q      <= 1'b0;
      pf_q      <= 1'b1;
    end else begin
      bat_sel_q <= bat_sel_d;
      en_q      <= !wdog_float_i && !bat_sel_d;
      pf_q      <= !bat_sel_d && !pf_cmp_low_i;
    end
  end

  supv_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .din    (wdog_i),
    .edge_o (kick)
  );

  supv_wdog_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .enable (en_q),
    .hold   (rst_active),
    .kick   (kick),
    .expire (expire)
  );

  supv_reset_seq #(.RESET_TICKS(RESET_TICKS)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .supply_low (sup_low_i),
    .wd_expire  (expire),
    .rst_active (rst_active)
  );

  assign rst_o     = rst_active;
  assign rst_n_o   = !rst_active;
  assign bat_sel_o = bat_sel_q;
  assign wdog_en_o = en_q;
  assign pfail_n_o = pf_q;

  // R6
  bat_release_chk: assert property (@(posedge clk) disable iff (rst)
    !sup_low_i |=> !bat_sel_o);

  // R6
  bat_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bat_sel_o) |-> $past(sup_low_i && sup_below_bat_i));

  // R7
  backup_force_chk: assert property (@(posedge clk) disable iff (rst)
    bat_sel_o |-> (!pfail_n_o && rst_o && !wdog_en_o));

  // R8
  pf_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !sup_low_i |=> (pfail_n_o == !$past(pf_cmp_low_i)));

  // R9
  wdog_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!wdog_en_o && !sup_low_i) |=> !$rose(rst_o));
endmodule

// File: tb/supv_ctrl_bench.sv
module supv_ctrl_bench;
  localparam int T = 32;
  localparam int R = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sup_low = 1'b0, below_bat = 1'b0, wd = 1'b0, wd_float = 1'b0, pf_low = 1'b0;
  logic rst_n_o, rst_o, pfail_n_o, bat_sel_o, wdog_en_o;

  always #10 clk = ~clk;   // 50 MHz

  supv_ctrl #(.TIMEOUT_TICKS(T), .RESET_TICKS(R), .SYNC_STAGES(2)) u_supv_ctrl (
    .clk(clk), .rst(rst), .sup_low_i(sup_low), .sup_below_bat_i(below_bat),
    .wdog_i(wd), .wdog_float_i(wd_float), .pf_cmp_low_i(pf_low),
    .rst_n_o(rst_n_o), .rst_o(rst_o), .pfail_n_o(pfail_n_o),
    .bat_sel_o(bat_sel_o), .wdog_en_o(wdog_en_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    int    sig;
    logic  val;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic push(input int at, input int sig, input logic val, input string tag);
    exp_t e;
    e.at = at; e.sig = sig; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic exp_rst(input int at, input logic v, input string tag);
    push(at, 0, v, tag);
    push(at, 1, ~v, {tag, " (R2)"});
  endtask

  function automatic logic pick(input int s);
    case (s)
      0: return rst_o;
      1: return rst_n_o;
      2: return pfail_n_o;
      3: return bat_sel_o;
      default: return wdog_en_o;
    endcase
  endfunction

  function automatic string sname(input int s);
    case (s)
      0: return "rst_o";
      1: return "rst_n_o";
      2: return "pfail_n_o";
      3: return "bat_sel_o";
      default: return "wdog_en_o";
    endcase
  endfunction

  // monitor: compare every queued item due in this cycle
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].at == cyc) begin
        checks++;
        if (pick(q[i].sig) !== q[i].val) begin
          errors++;
          $display("FAIL %s %s cyc=%0d actual=%b expected=%b",
                   q[i].tag, sname(q[i].sig), cyc, pick(q[i].sig), q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic wait_to(input int c);
    while (cyc < c) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run hung actual=running expected=finished");
    finish_run();
  end

  initial begin
    int n0, c0, c1, c2, c3, c4, c5, f, s, last;
    wait_to(3);
    n0 = cyc;
    // reset state seen at the edge that still sampled rst high
    exp_rst(n0, 1'b1, "R1");
    push(n0, 3, 1'b0, "R6");
    push(n0, 2, 1'b1, "R8");
    rst = 1'b0;
    exp_rst(n0 + R - 1, 1'b1, "R1");
    exp_rst(n0 + R, 1'b0, "R1");
    push(n0 + 2, 4, 1'b1, "R9");
    c0 = n0 + R;

    // R4: heartbeat stuck low
    exp_rst(c0 + T - 1, 1'b0, "R4");
    exp_rst(c0 + T, 1'b1, "R4");
    exp_rst(c0 + T + R - 1, 1'b1, "R4");
    exp_rst(c0 + T + R, 1'b0, "R4");
    exp_rst(c0 + 2*T + R - 1, 1'b0, "R4");
    exp_rst(c0 + 2*T + R, 1'b1, "R4");
    c1 = c0 + 2*T + 2*R;
    exp_rst(c1, 1'b0, "R4");

    // R10: one-cycle pulse
    wait_to(c1 + 10);
    wd = 1'b1;
    wait_to(c1 + 11);
    wd = 1'b0;
    exp_rst(c1 + T, 1'b0, "R10");
    exp_rst(c1 + 10 + 3 + T, 1'b0, "R10");
    exp_rst(c1 + 10 + 4 + T, 1'b1, "R10");
    c2 = c1 + 14 + T + R;

    // R3: regular toggling keeps reset off, then stops
    exp_rst(c2 + 40, 1'b0, "R3");
    exp_rst(c2 + 70, 1'b0, "R3");
    last = c2 + 5 + 8*9;
    exp_rst(last + 2 + T, 1'b0, "R3");
    exp_rst(last + 3 + T, 1'b1, "R3");
    for (int k = 0; k < 10; k++) begin
      wait_to(c2 + 5 + 8*k);
      wd = ~wd;
    end
    c3 = last + 3 + T + R;

    // R9: floating heartbeat disables the watchdog
    push(c3 + 1, 4, 1'b1, "R9");
    push(c3 + 3, 4, 1'b0, "R9");
    f = c3 + 3 + 2*T;
    exp_rst(f, 1'b0, "R9");
    exp_rst(f + T, 1'b0, "R9");
    exp_rst(f + T + 1, 1'b1, "R9");
    wait_to(c3 + 2);
    wd_float = 1'b1;
    wait_to(f);
    wd_float = 1'b0;
    c4 = f + T + 1 + R;

    // R8: power-fail output follows comparator
    push(c4 + 2, 2, 1'b1, "R8");
    push(c4 + 3, 2, 1'b0, "R8");
    push(c4 + 6, 2, 1'b1, "R8");
    wait_to(c4 + 2);
    pf_low = 1'b1;
    wait_to(c4 + 5);
    pf_low = 1'b0;

    // R5: supply low holds reset and stretches it
    s = c4 + 28;
    exp_rst(c4 + 9, 1'b1, "R5");
    exp_rst(s, 1'b1, "R5");
    push(s, 3, 1'b0, "R6");
    exp_rst(s + R - 1, 1'b1, "R5");
    exp_rst(s + R, 1'b0, "R5");
    wait_to(c4 + 8);
    sup_low = 1'b1;
    wait_to(s);
    sup_low = 1'b0;
    c5 = s + R;

    // R6 / R7: backup entry, hold and release
    push(c5 + 3, 3, 1'b0, "R6");
    exp_rst(c5 + 3, 1'b0, "R6");
    push(c5 + 5, 3, 1'b1, "R6");
    push(c5 + 5, 2, 1'b0, "R7");
    push(c5 + 5, 4, 1'b0, "R7");
    exp_rst(c5 + 5, 1'b1, "R7");
    push(c5 + 12, 3, 1'b1, "R6");
    push(c5 + 12, 2, 1'b0, "R7");
    push(c5 + 15, 3, 1'b0, "R6");
    push(c5 + 15, 2, 1'b1, "R8");
    push(c5 + 15, 4, 1'b1, "R9");
    exp_rst(c5 + 15, 1'b1, "R5");
    exp_rst(c5 + 14 + R, 1'b0, "R5");
    wait_to(c5 + 1);
    below_bat = 1'b1;
    wait_to(c5 + 4);
    sup_low = 1'b1;
    wait_to(c5 + 10);
    below_bat = 1'b0;
    wait_to(c5 + 14);
    sup_low = 1'b0;

    wait_to(c5 + 14 + R + 2);
    if (q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R1 scoreboard actual=%0d pending expected=0", q.size());
    end
    finish_run();
  end
endmodule